// File: doc/BRIEF.md
# Two-Wire Presence-Store Slave

This block is a slave on a two-wire serial bus (one clock line, one open-drain data line) that fronts a 256-byte store, such as the presence-detect bytes on a memory module. It runs on a fast system clock. It passes both bus lines through synchronizers and finds clock edges, start conditions and stop conditions in the synchronized signals. After a start, it shifts in an address byte. If the seven upper bits match its device address, it acknowledges by pulling the data line low during the ninth clock.

In write direction, the first byte after the address loads an internal byte pointer. Every later byte is stored at that pointer, and the pointer then advances. The slave acknowledges each of these bytes. In read direction, the slave sends the byte at the pointer, most significant bit first, and continues with the next byte only while the master acknowledges. When the master does not acknowledge, the slave goes silent until a stop condition. A stop condition always returns it to standby. The pointer keeps its value between transactions, so a random read is a pointer write, a repeated start, and then a read.

Top module: `spd_slave`

## Requirements
- R1: The slave changes its drive on the data line only after it detects a falling edge of the bus clock. The data line it drives therefore stays constant while the bus clock is high.
- R2: After reset the slave does not drive the data line. It ignores bus traffic until a start condition (data falling while the clock is high): a full address byte clocked in without a start gets no acknowledge.
- R3: A stop condition (data rising while the clock is high) returns the slave to standby from any state and releases the data line. A byte that follows a stop without a new start gets no acknowledge.
- R4: The address byte arrives MSB first and is sampled on rising clock edges. Bits 7..1 are the device address and bit 0 is the direction (1 = read). On a match the slave pulls the data line low through the ninth clock.
- R5: An address byte whose bits 7..1 do not match gets no acknowledge. The slave then ignores the bus until the next start.
- R6: In write direction, the first byte after the address loads the byte pointer and is acknowledged.
- R7: Each later written byte is stored at the pointer and acknowledged, and the pointer then advances by one.
- R8: In read direction, the slave drives the byte at the pointer MSB first, one bit per clock, and releases the line on the ninth clock. The pointer advances by one per byte sent.
- R9: If the master pulls the data line low on the ninth clock of a read byte, the slave sends the next byte.
- R10: If the master leaves the data line high on the ninth clock of a read byte, the slave stops driving. Until a stop it ignores everything, including start conditions, so an address sent after such a start gets no acknowledge.
- R11: The pointer wraps from 255 to 0, for both writes and reads.
- R12: A start that arrives before a stop aborts the transfer at any bit position. Address reception then begins again.
- R13: The pointer keeps its value across a stop. A read with no pointer write continues where the last transfer left off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Data line level as seen on the bus, asynchronous |
| sda_drive_low | output | 1 | When high, the pad pulls the data line low |

## Verification
Two events can fall in the same system cycle: a start condition, and the bit shifter or hold logic acting on the transfer in progress. The bench provokes this in two ways. It issues a start after three bits of a byte have been shifted in, and it issues a start while the slave is holding after a read byte that was not acknowledged. The outcome is judged at the pins. After the mid-byte start, the next address must be acknowledged and a later write and read-back must land at the new pointer. During the hold, the start must lose: the following address gets no acknowledge.

// File: rtl/spd_pkg.sv
package spd_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK,
        ST_HOLD
    } slv_state_e;

    typedef enum logic [1:0] {
        RX_ADDR,
        RX_PTR,
        RX_DATA
    } rx_kind_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [6:0] dev);
        return b[BYTE_W-1:1] == dev;
    endfunction

    function automatic rx_kind_e next_kind(input rx_kind_e k);
        return (k == RX_ADDR) ? RX_PTR : RX_DATA;
    endfunction

endpackage

// File: rtl/spd_line_sync.sv
module spd_line_sync #(
    parameter int STAGES = 2,
    parameter int LANES  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] raw,
    output logic [LANES-1:0] synced
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], raw[l]};
            end
        end
        assign synced[l] = chain[STAGES-1];
    end
endmodule

// File: rtl/spd_bus_cond.sv
module spd_bus_cond
    import spd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t ev
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/spd_store.sv
module spd_store #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/spd_slave.sv
module spd_slave
    import spd_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         AW          = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_drive_low
);
    localparam logic [AW-1:0]    PTR_ONE  = AW'(1);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [1:0]        sync_out;
    bus_evt_t          ev;
    slv_state_e        state;
    rx_kind_e          kind;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic [AW-1:0]     ptr;
    logic              is_read;
    logic              got_ack;
    logic              drv;
    logic              mem_we;
    logic [BYTE_W-1:0] rd_byte;
    logic              byte_end;

    spd_line_sync #(.STAGES(SYNC_STAGES), .LANES(2)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    ({scl_i, sda_i}),
        .synced (sync_out)
    );

    spd_bus_cond u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_s (sync_out[1]),
        .sda_s (sync_out[0]),
        .ev    (ev)
    );

    spd_store #(.AW(AW), .DW(BYTE_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .waddr (ptr),
        .wdata (sh),
        .raddr (ptr),
        .rdata (rd_byte)
    );

    assign byte_end = ev.scl_fall && (cnt == BIT_LAST);
    assign mem_we   = (state == ST_RX) && (kind == RX_DATA) && byte_end
                      && !ev.start && !ev.stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            kind    <= RX_ADDR;
            cnt     <= '0;
            sh      <= '0;
            ptr     <= '0;
            is_read <= 1'b0;
            got_ack <= 1'b0;
            drv     <= 1'b0;
        end else if (ev.stop) begin
            state <= ST_IDLE;
            drv   <= 1'b0;
        end else if (ev.start && state != ST_HOLD) begin
            state <= ST_RX;
            kind  <= RX_ADDR;
            cnt   <= '0;
            drv   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_RX: begin
                    if (ev.scl_rise && cnt < BIT_LAST) begin
                        sh  <= {sh[BYTE_W-2:0], ev.sda};
                        cnt <= cnt + CNT_ONE;
                    end else if (byte_end) begin
                        unique case (kind)
                            RX_ADDR: begin
                                if (addr_hit(sh, DEV_ADDR)) begin
                                    is_read <= sh[0];
                                    drv     <= 1'b1;
                                    state   <= ST_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            RX_PTR: begin
                                ptr   <= AW'(sh);
                                drv   <= 1'b1;
                                state <= ST_ACK;
                            end
                            default: begin
                                ptr   <= ptr + PTR_ONE;
                                drv   <= 1'b1;
                                state <= ST_ACK;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (ev.scl_fall) begin
                        cnt <= '0;
                        if (kind == RX_ADDR && is_read) begin
                            sh    <= rd_byte;
                            drv   <= ~rd_byte[BYTE_W-1];
                            state <= ST_TX;
                        end else begin
                            drv   <= 1'b0;
                            kind  <= next_kind(kind);
                            state <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.scl_rise) begin
                        cnt <= cnt + CNT_ONE;
                    end else if (byte_end) begin
                        drv   <= 1'b0;
                        ptr   <= ptr + PTR_ONE;
                        state <= ST_RACK;
                    end else if (ev.scl_fall && cnt != '0) begin
                        sh  <= {sh[BYTE_W-2:0], 1'b0};
                        drv <= ~sh[BYTE_W-2];
                    end
                end
                ST_RACK: begin
                    if (ev.scl_rise) begin
                        got_ack <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        cnt <= '0;
                        if (got_ack) begin
                            sh    <= rd_byte;
                            drv   <= ~rd_byte[BYTE_W-1];
                            state <= ST_TX;
                        end else begin
                            state <= ST_HOLD;
                        end
                    end
                end
                ST_HOLD: ;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign sda_drive_low = drv;

endmodule

// File: rtl/spd_slave_chk.sv
module spd_slave_chk
    import spd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             drive,
    input logic             scl_s,
    input logic             start_det,
    input logic             stop_det,
    input slv_state_e       state,
    input logic [CNT_W-1:0] cnt
);
    AST_DRIVE_ON_LOW_CLOCK: assert property (@(posedge clk) disable iff (rst)
        $rose(drive) |-> !scl_s); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        state == ST_IDLE |-> !drive); // R2

    AST_STOP_TO_STANDBY: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (state == ST_IDLE && !drive)); // R3

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(BYTE_W)); // R4

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        state == ST_HOLD |-> !drive); // R10

    AST_HOLD_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && start_det) |=> state == ST_HOLD); // R10

    AST_RESTART_ADDR: assert property (@(posedge clk) disable iff (rst)
        (start_det && !stop_det && state != ST_HOLD) |=> (state == ST_RX && cnt == '0)); // R12

    AST_NO_DUAL_COND: assert property (@(posedge clk) disable iff (rst)
        !(start_det && stop_det)); // R3
endmodule

bind spd_slave spd_slave_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .drive     (sda_drive_low),
    .scl_s     (ev.scl),
    .start_det (ev.start),
    .stop_det  (ev.stop),
    .state     (state),
    .cnt       (cnt)
);

// File: tb/tb_spd_slave.sv
`timescale 1ns/1ps
module tb_spd_slave;

    localparam int H = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_drive_low;
    logic sda_bus;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_drive_low;

    spd_slave dut (
        .clk           (clk),
        .rst           (rst),
        .scl_i         (scl_m),
        .sda_i         (sda_bus),
        .sda_drive_low (sda_drive_low)
    );

    task automatic wn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        wn(4); sda_m = 1'b1; wn(H); scl_m = 1'b1; wn(H);
        sda_m = 1'b0; wn(H); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wn(4); sda_m = 1'b0; wn(H); scl_m = 1'b1; wn(H);
        sda_m = 1'b1; wn(H);
    endtask

    task automatic bit_out(input logic b);
        wn(4); sda_m = b; wn(H); scl_m = 1'b1; wn(H); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        wn(4); sda_m = 1'b1; wn(H); scl_m = 1'b1; wn(H/2);
        acked = ~sda_bus;
        wn(H/2); scl_m = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v, output logic stable);
        logic a;
        stable = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wn(4); sda_m = 1'b1; wn(H); scl_m = 1'b1; wn(H/4);
            a = sda_bus;
            wn(H/2);
            if (sda_bus !== a) stable = 1'b0;
            v[i] = a;
            wn(H/4); scl_m = 1'b0;
        end
        wn(4); sda_m = ~give_ack; wn(H); scl_m = 1'b1; wn(H); scl_m = 1'b0;
        wn(4); sda_m = 1'b1;
    endtask

    task automatic t_reset();
        wn(8);
        chk("R2 reset release", {7'd0, sda_drive_low}, 8'h00);
    endtask

    task automatic t_no_start();
        logic ak;
        wn(H); scl_m = 1'b0;
        send_byte(8'hA0, ak);
        chk("R2 no start no ack", {7'd0, ak}, 8'h00);
        bus_stop();
    endtask

    task automatic t_write();
        logic ak;
        bus_start();
        send_byte(8'hA0, ak); chk("R4 address ack", {7'd0, ak}, 8'h01);
        send_byte(8'h10, ak); chk("R6 pointer ack", {7'd0, ak}, 8'h01);
        send_byte(8'h3C, ak); chk("R7 data ack 0", {7'd0, ak}, 8'h01);
        send_byte(8'hA5, ak); chk("R7 data ack 1", {7'd0, ak}, 8'h01);
        send_byte(8'h81, ak); chk("R7 data ack 2", {7'd0, ak}, 8'h01);
        send_byte(8'h5E, ak); chk("R7 data ack 3", {7'd0, ak}, 8'h01);
        bus_stop();
    endtask

    task automatic t_read();
        logic ak, st;
        logic [7:0] v;
        bus_start();
        send_byte(8'hA0, ak);
        send_byte(8'h10, ak);
        bus_start();
        send_byte(8'hA1, ak); chk("R4 read address ack", {7'd0, ak}, 8'h01);
        recv_byte(1'b1, v, st); chk("R8 read byte 0", v, 8'h3C);
        chk("R1 data stable while clock high", {7'd0, st}, 8'h01);
        recv_byte(1'b1, v, st); chk("R9 continue after ack", v, 8'hA5);
        recv_byte(1'b0, v, st); chk("R9 third byte", v, 8'h81);
        chk("R1 data stable third byte", {7'd0, st}, 8'h01);
        bus_stop();
    endtask

    task automatic t_nack();
        logic ak, st;
        logic [7:0] v;
        bus_start();
        send_byte(8'hA1, ak);
        recv_byte(1'b0, v, st); chk("R13 pointer kept across stop", v, 8'h5E);
        recv_byte(1'b0, v, st); chk("R10 silent after no ack", v, 8'hFF);
        bus_start();
        send_byte(8'hA1, ak); chk("R10 start ignored in hold", {7'd0, ak}, 8'h00);
        bus_stop();
    endtask

    task automatic t_mismatch();
        logic ak;
        bus_start();
        send_byte(8'hA2, ak); chk("R5 foreign address", {7'd0, ak}, 8'h00);
        send_byte(8'hA0, ak); chk("R5 idle until start", {7'd0, ak}, 8'h00);
        bus_stop();
    endtask

    task automatic t_stop_standby();
        logic ak;
        bus_start();
        send_byte(8'hA0, ak);
        bus_stop();
        wn(H); scl_m = 1'b0;
        send_byte(8'hA0, ak); chk("R3 standby after stop", {7'd0, ak}, 8'h00);
        bus_stop();
    endtask

    task automatic t_wrap();
        logic ak, st;
        logic [7:0] v;
        bus_start();
        send_byte(8'hA0, ak);
        send_byte(8'hFF, ak);
        send_byte(8'h11, ak);
        send_byte(8'h22, ak); chk("R11 write across wrap", {7'd0, ak}, 8'h01);
        bus_stop();
        bus_start();
        send_byte(8'hA0, ak);
        send_byte(8'hFF, ak);
        bus_start();
        send_byte(8'hA1, ak);
        recv_byte(1'b1, v, st); chk("R11 read at 255", v, 8'h11);
        recv_byte(1'b0, v, st); chk("R11 read wrapped to 0", v, 8'h22);
        bus_stop();
    endtask

    task automatic t_abort();
        logic ak, st;
        logic [7:0] v;
        bus_start();
        send_byte(8'hA0, ak);
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        bus_start();
        send_byte(8'hA0, ak); chk("R12 restart mid byte", {7'd0, ak}, 8'h01);
        send_byte(8'h40, ak);
        send_byte(8'h77, ak);
        bus_stop();
        bus_start();
        send_byte(8'hA0, ak);
        send_byte(8'h40, ak);
        bus_start();
        send_byte(8'hA1, ak);
        recv_byte(1'b0, v, st); chk("R12 write after restart", v, 8'h77);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        wn(6);
        rst = 1'b0;
        t_reset();
        t_no_start();
        t_write();
        t_read();
        t_nack();
        t_mismatch();
        t_stop_standby();
        t_wrap();
        t_abort();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule